// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the host side of an external byte-wide read-only memory with a 64K x 8 organisation. It takes a read request carrying a 16-bit address, presents that address on the memory bus, lowers the chip-select and output-enable strobes (both active low) in sequence, and captures the byte at a clock edge. It then hands the byte back with a single-cycle valid pulse.

All timing is counted in clock cycles. Each delay in nanoseconds is turned into a cycle count with ceiling division by the clock period. Both the clock period and the memory speed grade are parameters. Output-enable is lowered later than chip-select, as late as the access allows, so that both delays run out on the same edge. After each access both strobes are raised, and the controller waits for at least the memory's output-float time before it may select the device again. This means a slow device never drives the shared bus at the same time as the next one.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held low and on the first cycle after it is released, rom_ce_n and rom_oe_n are 1, rdata_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only when the controller is idle. A request is accepted at a clock edge where req_valid and req_ready are both 1, and req_ready is 0 on the next cycle.
- R3: rom_ce_n falls at the acceptance edge. From that edge rom_addr equals the accepted req_addr, and it does not change while rom_ce_n stays low.
- R4: rom_oe_n falls exactly ACC-OE cycles after rom_ce_n falls, where ACC and OE are the access and output-enable cycle counts. rom_oe_n is never 0 while rom_ce_n is 1.
- R5: Exactly ACC cycles after rom_ce_n falls, rdata takes the value on rom_data, and rom_ce_n and rom_oe_n both return to 1 at that same edge.
- R6: rdata_valid is high for exactly one cycle, ACC cycles after the acceptance edge, and one pulse is produced per accepted request, in request order.
- R7: Once the strobes rise, rom_ce_n stays high for at least FLT cycles, where FLT is the float cycle count. req_ready returns to 1 exactly ACC+FLT+1 cycles after the cycle in which the request was presented.
- R8: ACC, OE and FLT are each ceil(ns / CLK_PERIOD_NS). The nanosecond values come from SPEED_GRADE: grade 0 gives 90/40/35, grade 1 gives 120/50/25, grade 2 gives 150/50/45 and grade 3 gives 200/50/55 (access/output-enable/float).
- R9: A request presented while req_ready is 0 is ignored. It starts no access, and its address never reaches rom_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Byte address of the request |
| req_ready | output | 1 | Controller idle, request will be accepted |
| rdata | output | 8 | Byte read from memory |
| rdata_valid | output | 1 | One-cycle strobe marking rdata |
| rom_addr | output | 16 | Address bus to the memory |
| rom_ce_n | output | 1 | Chip select to the memory, active low |
| rom_oe_n | output | 1 | Output enable to the memory, active low |
| rom_data | input | 8 | Data bus from the memory |

## Verification
The assertions assume that reset is not asserted in the middle of an access. They also assume the memory holds rom_data valid whenever both strobes are low and the required cycles have passed, so they check only the strobe and address sequence, never the data. The bench keeps to these assumptions. Its memory model returns an address-derived byte only while both strobes are low, and a fixed filler byte otherwise, and it never pulses reset after start-up. The bench drives out-of-turn requests only while req_ready is low, and removes them before the controller returns to idle.

// File: rtl/eprom_rd_pkg.sv
// Shared types and timing helpers for the EPROM read controller.
// Assumes nanosecond figures are positive integers.
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_FLOAT  = 2'd2
    } seq_state_t;

    // Ceiling division of a delay by the clock period.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    // Address/select to data time per speed grade.
    function automatic int unsigned grade_access_ns(input int unsigned grade);
        case (grade)
            0:       return 90;
            1:       return 120;
            2:       return 150;
            default: return 200;
        endcase
    endfunction

    // Output-enable to data time per speed grade.
    function automatic int unsigned grade_oe_ns(input int unsigned grade);
        case (grade)
            0:       return 40;
            default: return 50;
        endcase
    endfunction

    // Output disable to bus float time per speed grade.
    function automatic int unsigned grade_float_ns(input int unsigned grade);
        case (grade)
            0:       return 35;
            1:       return 25;
            2:       return 45;
            default: return 55;
        endcase
    endfunction

endpackage

// File: rtl/eprom_step_counter.sv
// Phase counter for the read sequencer: loads 1, then counts up by one.
// Assumes the width holds the largest phase length plus one.
module eprom_step_counter #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    output logic [CW-1:0] count
);

    // Load restarts the phase at 1, increment advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= CW'(1);
        end else if (inc) begin
            count <= count + CW'(1);
        end
    end

endmodule

// File: rtl/eprom_read_seq.sv
// Read sequencer: idle -> access -> float -> idle.
// Issues single-cycle events: start (select), oe_go (enable outputs),
// sample (capture and release). Assumes ACC_CYC >= 1 and GAP_CYC < ACC_CYC.
module eprom_read_seq
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ACC_CYC = 5,
    parameter int unsigned GAP_CYC = 3,
    parameter int unsigned DF_CYC  = 2,
    parameter int unsigned CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic start,
    output logic oe_go,
    output logic sample
);

    localparam logic [CW-1:0] ACC_C = CW'(ACC_CYC);
    localparam logic [CW-1:0] GAP_C = CW'(GAP_CYC);
    localparam logic [CW-1:0] DF_C  = CW'(DF_CYC);

    seq_state_t    state, state_nx;
    logic [CW-1:0] count;
    logic          float_done;

    eprom_step_counter #(.CW(CW)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start || sample),
        .inc   (state != SEQ_IDLE),
        .count (count)
    );

    // Phase events decoded from state and phase count.
    always_comb begin
        req_ready  = (state == SEQ_IDLE);
        start      = req_ready && req_valid;
        sample     = (state == SEQ_ACCESS) && (count == ACC_C);
        float_done = (state == SEQ_FLOAT) && (count == DF_C);
    end

    // Output-enable timing: together with select when there is no slack.
    generate
        if (GAP_CYC == 0) begin : g_oe_with_ce
            assign oe_go = start;
        end else begin : g_oe_delayed
            assign oe_go = (state == SEQ_ACCESS) && (count == GAP_C);
        end
    endgenerate

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            SEQ_IDLE:   if (start)      state_nx = SEQ_ACCESS;
            SEQ_ACCESS: if (sample)     state_nx = (DF_CYC == 0) ? SEQ_IDLE : SEQ_FLOAT;
            SEQ_FLOAT:  if (float_done) state_nx = SEQ_IDLE;
            default:                    state_nx = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // R2: an accepted request makes the controller busy on the next cycle.
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R5: capture happens only during an access, never twice in a row.
    p_single_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

endmodule

// File: rtl/eprom_pin_stage.sv
// Registered memory-side pins and data capture.
// Assumes start, oe_go and sample come from the sequencer as one-cycle events.
module eprom_pin_stage #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          oe_go,
    input  logic          sample,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] rom_data,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid
);

    // Strobes, address latch and capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr    <= '0;
            rom_ce_n    <= 1'b1;
            rom_oe_n    <= 1'b1;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= sample;
            if (start) begin
                rom_ce_n <= 1'b0;
                rom_addr <= req_addr;
            end
            if (oe_go) begin
                rom_oe_n <= 1'b0;
            end
            if (sample) begin
                rom_ce_n <= 1'b1;
                rom_oe_n <= 1'b1;
                rdata    <= rom_data;
            end
        end
    end

    // R4: outputs enabled only while selected.
    p_oe_within_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);

    // R3: address steady through a selected period.
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

    // R6: valid is a single-cycle pulse.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    // R5: data strobe coincides with release of both enables.
    p_release_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (rom_ce_n && rom_oe_n));

endmodule

// File: rtl/eprom_rd_ctrl.sv
// Top of the parallel EPROM read controller.
// Converts the speed-grade delays to cycle counts and joins the sequencer
// with the pin stage. Assumes the memory meets the selected grade.
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned AW            = 16,
    parameter int unsigned DW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    output logic [AW-1:0] rom_addr,
    output logic          rom_ce_n,
    output logic          rom_oe_n,
    input  logic [DW-1:0] rom_data
);

    localparam int unsigned ACC_CYC = ns_to_cycles(grade_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned OE_CYC  = ns_to_cycles(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned DF_CYC  = ns_to_cycles(grade_float_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int unsigned GAP_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
    localparam int unsigned CW      = $clog2(ACC_CYC + DF_CYC + 2);

    logic start, oe_go, sample;

    eprom_read_seq #(
        .ACC_CYC (ACC_CYC),
        .GAP_CYC (GAP_CYC),
        .DF_CYC  (DF_CYC),
        .CW      (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .start     (start),
        .oe_go     (oe_go),
        .sample    (sample)
    );

    eprom_pin_stage #(.AW(AW), .DW(DW)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .oe_go       (oe_go),
        .sample      (sample),
        .req_addr    (req_addr),
        .rom_data    (rom_data),
        .rom_addr    (rom_addr),
        .rom_ce_n    (rom_ce_n),
        .rom_oe_n    (rom_oe_n),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    // Checker counters measuring strobe phases at the pins.
    logic [CW-1:0] ce_lo_cnt, oe_lo_cnt, ce_hi_cnt;

    // Count cycles each strobe has been low or high (high count saturates).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_lo_cnt <= '0;
            oe_lo_cnt <= '0;
            ce_hi_cnt <= CW'(DF_CYC);
        end else begin
            ce_lo_cnt <= rom_ce_n ? '0 : ce_lo_cnt + CW'(1);
            oe_lo_cnt <= rom_oe_n ? '0 : oe_lo_cnt + CW'(1);
            if (!rom_ce_n)                   ce_hi_cnt <= '0;
            else if (ce_hi_cnt < CW'(DF_CYC)) ce_hi_cnt <= ce_hi_cnt + CW'(1);
        end
    end

    // R5 R8: select held low for exactly the access cycle count.
    p_access_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (ce_lo_cnt == CW'(ACC_CYC)));

    // R4: outputs enabled for exactly the output-enable cycle count.
    p_oe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (oe_lo_cnt == CW'(OE_CYC)));

    // R7: float gap honoured before the next select.
    p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> (ce_hi_cnt >= CW'(DF_CYC)));

    // R9: select only starts from an accepted request.
    p_select_from_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> $past(req_valid && req_ready));

endmodule

// File: tb/eprom_rd_ctrl_bench.sv
// Scoreboard bench for eprom_rd_ctrl at grade 0 and a 20 ns clock.
module eprom_rd_ctrl_bench;

    localparam int CLK_NS = 20;
    localparam int GRADE  = 0;

    // Expected cycle counts, derived here from the requirement table (R8).
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    localparam int ACC_E = ceil_div((GRADE == 0) ? 90 : (GRADE == 1) ? 120 : (GRADE == 2) ? 150 : 200, CLK_NS);
    localparam int OE_E  = ceil_div((GRADE == 0) ? 40 : 50, CLK_NS);
    localparam int DF_E  = ceil_div((GRADE == 0) ? 35 : (GRADE == 1) ? 25 : (GRADE == 2) ? 45 : 55, CLK_NS);
    localparam int GAP_E = ACC_E - OE_E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic [15:0] rom_addr;
    logic        rom_ce_n, rom_oe_n;
    logic [7:0]  rom_data;

    always #(CLK_NS / 2) clk = ~clk;

    // Memory model: addressed byte while both enables low, filler otherwise.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h3C;
    endfunction
    assign rom_data = (!rom_ce_n && !rom_oe_n) ? mem_byte(rom_addr) : 8'hEE;

    eprom_rd_ctrl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(GRADE)) u_eprom_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_data(rom_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_reads = 0;
    int ce_falls = 0;
    bit done = 1'b0;
    logic [15:0] last_addr = '0;
    logic [7:0]  exp_dat_q[$];
    int          exp_cyc_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: present one request when ready and push the expectation.
    task automatic do_read(input logic [15:0] a);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        last_addr = a;
        n_reads++;
        exp_dat_q.push_back(mem_byte(a));
        exp_cyc_q.push_back(cyc + 1 + ACC_E);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
    endtask

    // Monitor: pin sequencing and result scoreboard, sampled at negedge.
    logic        p_ce = 1'b1, p_oe = 1'b1, p_valid = 1'b0;
    logic [15:0] p_addr = '0;
    int ce_fall_cyc = 0;
    int ce_rise_cyc = -1000;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ce && !rom_ce_n) begin
                ce_falls++;
                ce_fall_cyc = cyc;
                chk(rom_addr == last_addr, "R3", "address at select", rom_addr, last_addr);
                chk(cyc - ce_rise_cyc >= DF_E, "R7", "float gap", cyc - ce_rise_cyc, DF_E);
            end
            if (!p_ce && !rom_ce_n)
                chk(rom_addr == p_addr, "R3", "address stable", rom_addr, p_addr);
            if (p_oe && !rom_oe_n)
                chk(cyc - ce_fall_cyc == GAP_E, "R4", "oe delay after ce", cyc - ce_fall_cyc, GAP_E);
            if (!rom_oe_n && rom_ce_n)
                chk(1'b0, "R4", "oe low with ce high", rom_oe_n, 1);
            if (!p_ce && rom_ce_n) begin
                ce_rise_cyc = cyc;
                chk(cyc - ce_fall_cyc == ACC_E, "R5", "select length", cyc - ce_fall_cyc, ACC_E);
                chk(rom_oe_n == 1'b1, "R5", "oe released with ce", rom_oe_n, 1);
            end
            if (rdata_valid) begin
                chk(!p_valid, "R6", "valid pulse width", p_valid, 0);
                if (exp_dat_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected valid", 1, 0);
                end else begin
                    logic [7:0] ed;
                    int         ec;
                    ed = exp_dat_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    chk(rdata == ed, "R5", "read data", rdata, ed);
                    chk(cyc == ec, "R6 R8", "valid latency", cyc, ec);
                end
            end
        end
        p_ce = rom_ce_n;
        p_oe = rom_oe_n;
        p_addr = rom_addr;
        p_valid = rdata_valid;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        int c;
        @(negedge clk);
        @(negedge clk);
        // R1: state during reset.
        chk(rom_ce_n == 1'b1, "R1", "ce in reset", rom_ce_n, 1);
        chk(rom_oe_n == 1'b1, "R1", "oe in reset", rom_oe_n, 1);
        chk(rdata_valid == 1'b0, "R1", "valid in reset", rdata_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rom_ce_n == 1'b1, "R1", "ce after reset", rom_ce_n, 1);

        // Several address patterns, back to back.
        do_read(16'h0000);
        do_read(16'hFFFF);
        do_read(16'h1234);
        do_read(16'hA5A5);
        do_read(16'h00FF);

        // R7: ready returns after access plus float time.
        while (!req_ready || exp_dat_q.size() != 0) @(negedge clk);
        c = cyc;
        do_read(16'h4321);
        while (!req_ready) @(negedge clk);
        chk(cyc == c + 1 + ACC_E + DF_E, "R7", "ready return cycle", cyc - c, 1 + ACC_E + DF_E);

        // R9: a request while busy is ignored.
        do_read(16'h0F0F);
        req_valid = 1'b1;
        req_addr  = 16'hBEEF;
        repeat (3) begin
            chk(req_ready == 1'b0, "R9", "busy while request pending", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!req_ready || exp_dat_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ce_falls == n_reads, "R9", "select count", ce_falls, n_reads);
        chk(rom_addr == 16'h0F0F, "R9", "ignored address absent", rom_addr, 16'h0F0F);
        chk(exp_dat_q.size() == 0, "R6", "scoreboard drained", exp_dat_q.size(), 0);
        finish_run();
    end

endmodule